// File: doc/BRIEF.md
# Quad DAC Serial Command Transmitter

This block is the host-side driver for a four-output, 8-bit digital-to-analog converter controlled over four wires: a serial clock, a serial data line and two active-low strobes. A request carries a 2-bit output selector, a gain bit and an 8-bit code. The block shifts these out as one 11-bit word, most significant bit first, then pulses the commit strobe low to latch the word into the converter's input register.

A second active-low strobe moves the latched codes to the analog outputs. The host raises a dedicated update input to pulse it. When the auto-update option is set at the time a write is accepted, the block pulses it on its own right after that write's commit pulse. A divider input, captured when each request is accepted, sets the length of half a serial bit in system clock cycles. This lets one design serve converters and boards of different speeds.

Top module: `qdac_serial_tx`

## Requirements
- R1: After reset, the serial clock is low, both strobes (commit and update) are high and `req_ready_o` is high. These idle levels also hold whenever `req_ready_o` is high.
- R2: Each write sends exactly 11 bits, most significant first. The word is {selector[1:0], gain, code[7:0]}, so word bits 10:9 are the selector (0..3 address outputs A..D), bit 8 is the gain and bits 7:0 are the code.
- R3: With H = max(divider, 1), every high phase of the serial clock lasts H system cycles and every low phase between bits lasts H cycles. A divider of 0 behaves as 1.
- R4: The data line does not change while the serial clock is high, nor in the cycle the serial clock falls. It changes only while the clock is low.
- R5: After the 11th falling edge of the serial clock, the commit strobe falls H cycles later, stays low for 2H cycles and then returns high. It pulses exactly once per write.
- R6: If the auto-update input is high when a write is accepted, the update strobe falls in the same cycle the commit strobe rises and stays low for 2H cycles.
- R7: A pulse on the update input while idle, with no write request in that cycle, drives the update strobe low for 2H cycles. It produces no serial clock edges and no commit pulse.
- R8: `req_ready_o` is low from the cycle after acceptance until the sequence ends: 25H cycles for a write, 27H with auto-update, 2H for an update. Requests and update pulses seen while it is low are ignored. A write request and an update pulse in the same idle cycle start only the write.
- R9: The divider is captured at acceptance. Changing it during a sequence does not change that sequence's timing.
- R10: If the auto-update input is low when a write is accepted, that write produces no update pulse.
- R11: The commit and update strobes are never low together, and the serial clock is low whenever either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Block idle, request or update accepted |
| req_chan_i | input | 2 | Output selector (0..3 = A..D) |
| req_gain_i | input | 1 | Gain bit |
| req_code_i | input | 8 | Converter code |
| upd_pulse_i | input | 1 | Request a standalone update strobe |
| auto_upd_i | input | 1 | Follow each write with an update strobe |
| half_div_i | input | 8 | Half serial bit period in system cycles |
| dac_sclk_o | output | 1 | Serial clock, idles low |
| dac_sdata_o | output | 1 | Serial data |
| dac_load_n_o | output | 1 | Commit strobe, active low |
| dac_ldac_n_o | output | 1 | Output update strobe, active low |

## Verification
A corrupted shift register or bit counter shows up within one frame. The word decoded on serial clock falls then differs from the request, or the commit strobe falls after a count other than 11, and this is visible by the end of the frame (at most 25H cycles). A stuck sequencer state or a mis-latched divider shows up as a wrong pulse width, gap or ready-low length, measured in whole system cycles at that first frame. A bad pulse ordering breaks the strobe overlap rule in the cycle it happens.

// File: rtl/qdac_pkg.sv
// Shared types for the quad DAC serial transmitter.
package qdac_pkg;
    // Sequencer states; each waits for half-period ticks.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_GAP,
        ST_LOAD,
        ST_LDAC
    } qdac_state_e;
endpackage

// File: rtl/qdac_half_timer.sv
// Half-period timer: while run_i is high, emits a one-cycle tick every
// (lim_i + 1) system cycles. Held cleared while run_i is low so the first
// tick comes exactly lim_i + 1 cycles after run_i rises.
// Assumes lim_i is stable while run_i is high.
module qdac_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] lim_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    // Tick when the count reaches the limit.
    assign tick_o = run_i && (cnt_q >= lim_i);

    // Count system cycles within the current half period.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/qdac_frame_seq.sv
// Frame sequencer: shifts a FRAME_W-bit word MSB first on a low-idle
// serial clock, then pulses the commit strobe low for two ticks, then
// optionally the update strobe for two ticks. Also runs a standalone
// update pulse. All line outputs are registered.
// Assumes start_wr_i and start_upd_i are only raised while busy_o is low
// and never together.
module qdac_frame_seq
    import qdac_pkg::*;
#(
    parameter int FRAME_W = 11
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_wr_i,
    input  logic               start_upd_i,
    input  logic [FRAME_W-1:0] word_i,
    input  logic               auto_i,
    input  logic               tick_i,
    output logic               busy_o,
    output logic               sclk_o,
    output logic               sdata_o,
    output logic               load_n_o,
    output logic               ldac_n_o
);
    localparam int CNT_W = $clog2(FRAME_W);

    qdac_state_e        state_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   left_q;
    logic               pend_q;
    logic               phase_q;
    logic               auto_q;
    logic               sclk_q;
    logic               load_n_q;
    logic               ldac_n_q;

    // Output mapping: data is the shift register MSB.
    assign busy_o   = (state_q != ST_IDLE);
    assign sclk_o   = sclk_q;
    assign sdata_o  = shreg_q[FRAME_W-1];
    assign load_n_o = load_n_q;
    assign ldac_n_o = ldac_n_q;

    // Sequencer: advances on ticks, shifts one cycle after each clock fall.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q  <= ST_IDLE;
            shreg_q  <= '0;
            left_q   <= '0;
            pend_q   <= 1'b0;
            phase_q  <= 1'b0;
            auto_q   <= 1'b0;
            sclk_q   <= 1'b0;
            load_n_q <= 1'b1;
            ldac_n_q <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_wr_i) begin
                        shreg_q <= word_i;
                        left_q  <= CNT_W'(FRAME_W - 1);
                        auto_q  <= auto_i;
                        pend_q  <= 1'b0;
                        state_q <= ST_BIT_LO;
                    end else if (start_upd_i) begin
                        ldac_n_q <= 1'b0;
                        phase_q  <= 1'b0;
                        state_q  <= ST_LDAC;
                    end
                end
                ST_BIT_LO: begin
                    if (pend_q) begin
                        shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                        pend_q  <= 1'b0;
                    end
                    if (tick_i) begin
                        sclk_q  <= 1'b1;
                        state_q <= ST_BIT_HI;
                    end
                end
                ST_BIT_HI: begin
                    if (tick_i) begin
                        sclk_q <= 1'b0;
                        if (left_q == '0) begin
                            state_q <= ST_GAP;
                        end else begin
                            left_q  <= left_q - CNT_W'(1);
                            pend_q  <= 1'b1;
                            state_q <= ST_BIT_LO;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick_i) begin
                        load_n_q <= 1'b0;
                        phase_q  <= 1'b0;
                        state_q  <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (tick_i) begin
                        if (phase_q) begin
                            load_n_q <= 1'b1;
                            phase_q  <= 1'b0;
                            if (auto_q) begin
                                ldac_n_q <= 1'b0;
                                state_q  <= ST_LDAC;
                            end else begin
                                state_q  <= ST_IDLE;
                            end
                        end else begin
                            phase_q <= 1'b1;
                        end
                    end
                end
                ST_LDAC: begin
                    if (tick_i) begin
                        if (phase_q) begin
                            ldac_n_q <= 1'b1;
                            phase_q  <= 1'b0;
                            state_q  <= ST_IDLE;
                        end else begin
                            phase_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qdac_serial_tx.sv
// Top: quad DAC serial command transmitter. Accepts a write (selector,
// gain, code) or a standalone update pulse while idle, captures the
// divider, and drives the four converter control lines.
// Assumes request fields are valid in the cycle req_valid_i is high.
module qdac_serial_tx #(
    parameter int CHAN_W = 2,
    parameter int CODE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [CHAN_W-1:0] req_chan_i,
    input  logic              req_gain_i,
    input  logic [CODE_W-1:0] req_code_i,
    input  logic              upd_pulse_i,
    input  logic              auto_upd_i,
    input  logic [DIV_W-1:0]  half_div_i,
    output logic              dac_sclk_o,
    output logic              dac_sdata_o,
    output logic              dac_load_n_o,
    output logic              dac_ldac_n_o
);
    localparam int FRAME_W = CHAN_W + 1 + CODE_W;

    logic             busy;
    logic             tick;
    logic             take_wr;
    logic             take_upd;
    logic [DIV_W-1:0] lim_q;

    // Handshake: writes win over a same-cycle update pulse.
    assign req_ready_o = !busy;
    assign take_wr     = req_valid_i && !busy;
    assign take_upd    = upd_pulse_i && !req_valid_i && !busy;

    // Capture the half-period limit (divider - 1, floor 0) at acceptance.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lim_q <= '0;
        end else if (take_wr || take_upd) begin
            lim_q <= (half_div_i == '0) ? '0 : half_div_i - DIV_W'(1);
        end
    end

    qdac_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (busy),
        .lim_i  (lim_q),
        .tick_o (tick)
    );

    qdac_frame_seq #(.FRAME_W(FRAME_W)) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_wr_i  (take_wr),
        .start_upd_i (take_upd),
        .word_i      ({req_chan_i, req_gain_i, req_code_i}),
        .auto_i      (auto_upd_i),
        .tick_i      (tick),
        .busy_o      (busy),
        .sclk_o      (dac_sclk_o),
        .sdata_o     (dac_sdata_o),
        .load_n_o    (dac_load_n_o),
        .ldac_n_o    (dac_ldac_n_o)
    );
endmodule

// File: rtl/qdac_serial_tx_chk.sv
// Protocol checker for qdac_serial_tx, bound to every instance.
// Measures strobe widths against the captured half-period limit.
module qdac_serial_tx_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ready_i,
    input logic             valid_i,
    input logic             upd_i,
    input logic             sclk_i,
    input logic             sdata_i,
    input logic             load_n_i,
    input logic             ldac_n_i,
    input logic [DIV_W-1:0] lim_i
);
    logic [DIV_W+1:0] load_w_q;
    logic [DIV_W+1:0] ldac_w_q;
    logic [DIV_W+1:0] two_h;

    assign two_h = ({2'b00, lim_i} + (DIV_W+2)'(1)) << 1;

    // Count cycles each strobe spends low.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            load_w_q <= '0;
            ldac_w_q <= '0;
        end else begin
            load_w_q <= load_n_i ? '0 : load_w_q + (DIV_W+2)'(1);
            ldac_w_q <= ldac_n_i ? '0 : ldac_w_q + (DIV_W+2)'(1);
        end
    end

    AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_i |-> (!sclk_i && load_n_i && ldac_n_i)); // R1
    AST_DATA_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_i && $past(sclk_i)) |-> $stable(sdata_i)); // R4
    AST_DATA_HELD_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sclk_i) |-> $stable(sdata_i)); // R4
    AST_LOAD_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(load_n_i) |-> (load_w_q == two_h)); // R5
    AST_LDAC_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ldac_n_i) |-> (ldac_w_q == two_h)); // R6
    AST_READY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ready_i) |-> ($past(valid_i) || $past(upd_i))); // R8
    AST_STROBE_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!load_n_i && !ldac_n_i)); // R11
    AST_CLK_LOW_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_n_i || !ldac_n_i) |-> !sclk_i); // R11
endmodule

bind qdac_serial_tx qdac_serial_tx_chk #(.DIV_W(DIV_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ready_i  (req_ready_o),
    .valid_i  (req_valid_i),
    .upd_i    (upd_pulse_i),
    .sclk_i   (dac_sclk_o),
    .sdata_i  (dac_sdata_o),
    .load_n_i (dac_load_n_o),
    .ldac_n_i (dac_ldac_n_o),
    .lim_i    (lim_q)
);

// File: tb/tb_qdac_serial_tx.sv
// Directed bench: each task runs one scenario and checks its own results.
module tb_qdac_serial_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic       ready;
    logic [1:0] chan = '0;
    logic       gain = 1'b0;
    logic [7:0] code = '0;
    logic       upd = 1'b0;
    logic       auto_u = 1'b0;
    logic [7:0] div = 8'd1;
    logic       sclk, sdata, load_n, ldac_n;

    int total = 0;
    int bad = 0;
    int exp_h = 1;

    // Monitor state, written only by the monitor process.
    int cyc = 0;
    logic p_sclk = 1'b0, p_data = 1'b0, p_load = 1'b1, p_ldac = 1'b1;
    logic [10:0] sh_word = '0;
    int sh_bits = 0, hi_run = 0, hi_bad = 0, r4_bad = 0, ovl_bad = 0;
    int t_fall = 0, falls = 0;
    logic [10:0] fr_word = '0;
    int fr_bits = 0, gap = 0;
    int load_pulses = 0, load_run = 0, load_w = 0, t_load_rise = 0;
    int ldac_pulses = 0, ldac_run = 0, ldac_w = 0, ldac_lag = 0;

    always #2 clk = ~clk;

    qdac_serial_tx dut (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
        .req_chan_i(chan), .req_gain_i(gain), .req_code_i(code),
        .upd_pulse_i(upd), .auto_upd_i(auto_u), .half_div_i(div),
        .dac_sclk_o(sclk), .dac_sdata_o(sdata),
        .dac_load_n_o(load_n), .dac_ldac_n_o(ldac_n)
    );

    // Line monitor: decodes frames and measures pulse timing at negedges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk) hi_run++;
            if (sclk && p_sclk && sdata != p_data) r4_bad++;
            if (!sclk && p_sclk) begin
                if (hi_run != exp_h) hi_bad++;
                hi_run = 0;
                if (sdata != p_data) r4_bad++;
                sh_word = {sh_word[9:0], sdata};
                sh_bits++;
                falls++;
                t_fall = cyc;
            end
            if (!load_n && p_load) begin
                fr_word = sh_word; fr_bits = sh_bits; sh_bits = 0;
                gap = cyc - t_fall;
            end
            if (!load_n) load_run++;
            if (load_n && !p_load) begin
                load_w = load_run; load_run = 0; load_pulses++; t_load_rise = cyc;
            end
            if (!ldac_n && p_ldac) ldac_lag = cyc - t_load_rise;
            if (!ldac_n) ldac_run++;
            if (ldac_n && !p_ldac) begin
                ldac_w = ldac_run; ldac_run = 0; ldac_pulses++;
            end
            if ((!load_n && !ldac_n) || (sclk && (!load_n || !ldac_n))) ovl_bad++;
        end
        p_sclk = sclk; p_data = sdata; p_load = load_n; p_ldac = ldac_n;
        cyc++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write; optionally change divider, poke inputs while busy, or raise update with it.
    task automatic do_write(input logic [1:0] ch, input logic g, input logic [7:0] v,
                            input int dv, input int new_dv, input bit au,
                            input bit poke, input bit both);
        int h = (dv < 1) ? 1 : dv;
        int lp0 = load_pulses, dp0 = ldac_pulses, hb0 = hi_bad, r40 = r4_bad;
        int busy_n = 0;
        exp_h = h;
        @(negedge clk);
        chan = ch; gain = g; code = v; div = 8'(dv); auto_u = au;
        valid = 1'b1; upd = both;
        @(negedge clk);
        check(ready == 1'b0, "R8 ready drops", int'(ready), 0);
        busy_n = 1;
        valid = 1'b0; upd = 1'b0; div = 8'(new_dv);
        while (!ready) begin
            @(negedge clk);
            if (poke && busy_n < 6) begin
                valid = 1'b1; upd = 1'b1; chan = ~ch; code = ~v;
            end else begin
                valid = 1'b0; upd = 1'b0;
            end
            if (!ready) busy_n++;
        end
        valid = 1'b0; upd = 1'b0;
        repeat (3) @(negedge clk);
        check(fr_bits == 11, "R2 bit count", fr_bits, 11);
        check(fr_word == {ch, g, v}, "R2 word", int'(fr_word), int'({ch, g, v}));
        check(hi_bad == hb0, "R3 high phase width", hi_bad - hb0, 0);
        check(r4_bad == r40, "R4 data stability", r4_bad - r40, 0);
        check(load_pulses == lp0 + 1, "R5 commit count", load_pulses - lp0, 1);
        check(load_w == 2 * h, "R5 commit width", load_w, 2 * h);
        check(gap == h, "R5 commit gap", gap, h);
        check(busy_n == (au ? 27 : 25) * h, "R8 R9 busy length", busy_n, (au ? 27 : 25) * h);
        if (au) begin
            check(ldac_pulses == dp0 + 1, "R6 update count", ldac_pulses - dp0, 1);
            check(ldac_w == 2 * h, "R6 update width", ldac_w, 2 * h);
            check(ldac_lag == 0, "R6 update lag", ldac_lag, 0);
        end else begin
            check(ldac_pulses == dp0, "R10 R8 no update", ldac_pulses - dp0, 0);
        end
    endtask

    // Standalone update strobe.
    task automatic do_update(input int dv);
        int h = (dv < 1) ? 1 : dv;
        int lp0 = load_pulses, dp0 = ldac_pulses, f0 = falls;
        int busy_n = 0;
        @(negedge clk);
        div = 8'(dv); upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        busy_n = ready ? 0 : 1;
        while (!ready) begin
            @(negedge clk);
            if (!ready) busy_n++;
        end
        repeat (2) @(negedge clk);
        check(ldac_pulses == dp0 + 1, "R7 update count", ldac_pulses - dp0, 1);
        check(ldac_w == 2 * h, "R7 update width", ldac_w, 2 * h);
        check(load_pulses == lp0, "R7 no commit", load_pulses - lp0, 0);
        check(falls == f0, "R7 no clock edges", falls - f0, 0);
        check(busy_n == 2 * h, "R8 update busy", busy_n, 2 * h);
    endtask

    task automatic check_reset();
        repeat (2) @(negedge clk);
        check(sclk == 1'b0, "R1 sclk idle", int'(sclk), 0);
        check(load_n == 1'b1, "R1 load idle", int'(load_n), 1);
        check(ldac_n == 1'b1, "R1 ldac idle", int'(ldac_n), 1);
        check(ready == 1'b1, "R1 ready", int'(ready), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset();
        do_write(2'd0, 1'b0, 8'hA5, 1, 1, 1'b0, 1'b0, 1'b0);
        do_write(2'd3, 1'b1, 8'h3C, 3, 3, 1'b1, 1'b0, 1'b0);
        do_write(2'd1, 1'b0, 8'hFF, 0, 0, 1'b0, 1'b0, 1'b0);   // R3 divider 0
        do_write(2'd2, 1'b1, 8'h00, 2, 7, 1'b0, 1'b0, 1'b0);   // R9 divider change
        do_update(2);
        do_write(2'd1, 1'b1, 8'h81, 2, 2, 1'b0, 1'b1, 1'b0);   // R8 busy pokes
        do_write(2'd2, 1'b0, 8'h5A, 1, 1, 1'b0, 1'b0, 1'b1);   // R8 write wins
        do_write(2'd3, 1'b0, 8'h7E, 4, 1, 1'b1, 1'b0, 1'b0);
        check(ovl_bad == 0, "R11 strobe overlap", ovl_bad, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule